// File: doc/BRIEF.md
# Nested Interrupt Priority Arbiter

This block picks the interrupt that a small CPU core takes next. Every maskable source has a pending latch, an enable and a 2-bit software level. It also has a fixed hardware rank given by its index. Three non-maskable sources sit above all of them: a reset request, a top-level pin and a software trap. Arbitration is a combinational two-stage choice. The highest software level among the eligible sources wins first. The fixed hardware rank is consulted only to break a tie inside that level.

The core sees the current winner as a vector code together with a valid flag. It commits entry with a single-cycle acknowledge. On entry the block registers an entry strobe, the vector code and a flag telling whether registers must be stacked. It also updates its 2-bit current-level register. The core restores the interrupted level through a restore port on return.

The low maskable sources are external lines. Each one is fed by a group of pins: the selected pins are ORed together, and a rising edge of that OR is latched. The remaining sources are peripheral requests, latched while asserted. A wake output ends halt mode when an enabled external line or a non-maskable source is pending.

Top module: `nest_irq_arbiter`

## Requirements
- R1: Among the eligible maskable sources, the winner has the highest software level (src_lvl bits [2i+1:2i] for source i, 0..3).
- R2: When several eligible sources share the highest level, the lowest index wins. Maskable source i has vector code i+3.
- R3: A maskable source is eligible only when it is pending, its enable is set and its level is strictly greater than cur_lvl. Otherwise it stays pending without winning, so at level 3 no maskable source wins.
- R4: Pending non-maskable sources win over every maskable source whatever the level. Among them the order is reset (code 0), then pin (code 1), then trap (code 2).
- R5: Entry of a non-maskable source sets cur_lvl to 3. Entry of a maskable source loads cur_lvl with that source's level. Both take effect at the accepting clock edge.
- R6: ent_stack is 0 for a reset entry (code 0) and 1 for every other entry.
- R7: An external source latches a rising edge of its group's OR. Its latch is cleared by its own entry, and a line held high does not latch again.
- R8: Within a group, pins whose pin_sel bit is 0 have no effect. Selected pins are ORed.
- R9: src_clr[i] discards source i's pending request. A peripheral latch is cleared only by src_clr and is not cleared by its entry.
- R10: An entry is accepted when core_ack is high, win_valid is high and the block is armed. An acceptance disarms the block, and core_ack is ignored until core_ready re-arms it.
- R11: A ret_stb pulse loads cur_lvl from ret_lvl at the next edge, unless an entry is accepted in that same cycle.
- R12: wake is high when an enabled external source is pending or any non-maskable source is pending.
- R13: After reset, cur_lvl is 3, nothing is pending, win_valid, ent_stb and wake are 0, and the block is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | N_EXT*GRP_PINS | External pins, group g at bits [g*GRP_PINS +: GRP_PINS] |
| pin_sel | input | N_EXT*GRP_PINS | Pin selection mask for the OR of each group |
| per_req | input | N_PER | Peripheral requests, source N_EXT+j |
| src_en | input | N_SRC | Enable per maskable source |
| src_lvl | input | 2*N_SRC | Software level per maskable source |
| src_clr | input | N_SRC | Clear sequence per source |
| nmi_reset | input | 1 | Reset-source request |
| nmi_pin | input | 1 | Top-level pin, rising edge latched |
| nmi_trap | input | 1 | Trap instruction request |
| core_ack | input | 1 | Core acknowledge of the current winner |
| core_ready | input | 1 | Core ready for a new acknowledge |
| ret_stb | input | 1 | Return-from-interrupt strobe |
| ret_lvl | input | 2 | Level to restore on return |
| cur_lvl | output | 2 | Current level register |
| win_valid | output | 1 | A winner exists |
| win_vec | output | VEC_W | Vector code of the winner |
| ent_stb | output | 1 | One-cycle entry strobe |
| ent_vec | output | VEC_W | Vector code of the entered source |
| ent_stack | output | 1 | Entry requires register stacking |
| wake | output | 1 | Halt wake request |

## Verification
The main arbitration is tried with a table of peripheral request patterns. Distinct levels show that the software level decides first. Equal levels show that the hardware rank breaks ties, and a mix of high and low levels shows that a high level beats a lower index. Equal-to-current and disabled sources show that masking does not depend on rank. Directed sequences then cover the following:
- simultaneous non-maskable requests against a level-3 maskable one, which separates exclusive non-maskable precedence from ordinary level comparison;
- group pin toggles, which separate selected from unselected pins and new edges from held levels;
- acknowledges given while disarmed, which must be ignored.

// File: rtl/nia_pkg.sv
package nia_pkg;

    localparam int LVL_W   = 2;
    localparam int NMI_CNT = 3;

    typedef logic [LVL_W-1:0] lvl_t;

    localparam lvl_t LVL_TOP = 2'd3;

    typedef enum logic [1:0] {
        NMI_RST  = 2'd0,
        NMI_PIN  = 2'd1,
        NMI_TRAP = 2'd2
    } nmi_code_e;

    typedef struct packed {
        logic trap;
        logic pin;
        logic rst;
    } nmi_set_t;

    typedef struct packed {
        logic stb;
        logic stack;
    } entry_t;

    function automatic int vec_width(input int n_src);
        return $clog2(n_src + NMI_CNT);
    endfunction

    function automatic logic nmi_any(input nmi_set_t s);
        return s.rst | s.pin | s.trap;
    endfunction

endpackage

// File: rtl/irq_ext_group.sv
module irq_ext_group #(
    parameter int N_EXT    = 2,
    parameter int GRP_PINS = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_EXT*GRP_PINS-1:0] pin_in,
    input  logic [N_EXT*GRP_PINS-1:0] pin_sel,
    output logic [N_EXT-1:0]          rise
);
    logic [N_EXT-1:0] line_now;
    logic [N_EXT-1:0] line_prev;

    for (genvar g = 0; g < N_EXT; g++) begin : g_grp
        assign line_now[g] = |(pin_in[g*GRP_PINS +: GRP_PINS] & pin_sel[g*GRP_PINS +: GRP_PINS]);
        assign rise[g]     = line_now[g] & ~line_prev[g];
    end

    always_ff @(posedge clk) begin
        if (rst) line_prev <= '0;
        else     line_prev <= line_now;
    end

    // a held line cannot report a second rising edge
    for (genvar g = 0; g < N_EXT; g++) begin : g_chk
        p_single_edge_r7: assert property (@(posedge clk) disable iff (rst)
            rise[g] |=> !rise[g]);
    end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int N_EXT = 2,
    parameter int N_PER = 4,
    localparam int N_SRC = N_EXT + N_PER
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_EXT-1:0] ext_rise,
    input  logic [N_PER-1:0] per_req,
    input  logic [N_SRC-1:0] clr,
    input  logic [N_SRC-1:0] ent_clr,
    output logic [N_SRC-1:0] pend
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        if (i < N_EXT) begin : g_edge
            always_ff @(posedge clk) begin
                if (rst) pend[i] <= 1'b0;
                else     pend[i] <= (pend[i] | ext_rise[i]) & ~clr[i] & ~ent_clr[i];
            end
            p_entry_clears_r7: assert property (@(posedge clk) disable iff (rst)
                ent_clr[i] |=> !pend[i]);
        end else begin : g_level
            always_ff @(posedge clk) begin
                if (rst) pend[i] <= 1'b0;
                else     pend[i] <= (pend[i] | per_req[i-N_EXT]) & ~clr[i];
            end
            p_entry_keeps_r9: assert property (@(posedge clk) disable iff (rst)
                (pend[i] && !clr[i]) |=> pend[i]);
        end
        p_clear_drops_r9: assert property (@(posedge clk) disable iff (rst)
            clr[i] |=> !pend[i]);
    end
endmodule

// File: rtl/irq_two_stage_pick.sv
module irq_two_stage_pick
    import nia_pkg::*;
#(
    parameter int N_SRC = 6,
    localparam int VEC_W = vec_width(N_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_SRC-1:0]   pend,
    input  logic [N_SRC-1:0]   en,
    input  logic [2*N_SRC-1:0] lvl,
    input  lvl_t               cur,
    input  nmi_set_t           nmi_pend,
    output logic               win_valid,
    output logic               win_nmi,
    output lvl_t               win_lvl,
    output logic [VEC_W-1:0]   win_code
);
    logic [N_SRC-1:0] cand;
    lvl_t             best;
    logic             any;
    int               sel;

    for (genvar i = 0; i < N_SRC; i++) begin : g_cand
        assign cand[i] = pend[i] & en[i] & (lvl[2*i +: 2] > cur);
    end

    always_comb begin
        best = '0;
        any  = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (cand[i] && (!any || lvl[2*i +: 2] > best)) begin
                best = lvl[2*i +: 2];
                any  = 1'b1;
            end
        end
        sel = 0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (cand[i] && lvl[2*i +: 2] == best) sel = i;
        end
        win_valid = 1'b0;
        win_nmi   = 1'b0;
        win_lvl   = '0;
        win_code  = '0;
        if (nmi_any(nmi_pend)) begin
            win_valid = 1'b1;
            win_nmi   = 1'b1;
            win_lvl   = LVL_TOP;
            if (nmi_pend.rst)      win_code = VEC_W'(NMI_RST);
            else if (nmi_pend.pin) win_code = VEC_W'(NMI_PIN);
            else                   win_code = VEC_W'(NMI_TRAP);
        end else if (any) begin
            win_valid = 1'b1;
            win_lvl   = best;
            win_code  = VEC_W'(sel + NMI_CNT);
        end
    end

    p_win_above_level_r3: assert property (@(posedge clk) disable iff (rst)
        (win_valid && !win_nmi) |-> (win_lvl > cur));
    p_nmi_first_r4: assert property (@(posedge clk) disable iff (rst)
        nmi_pend.rst |-> (win_nmi && win_code == '0));
endmodule

// File: rtl/nest_irq_arbiter.sv
module nest_irq_arbiter
    import nia_pkg::*;
#(
    parameter int N_EXT    = 2,
    parameter int GRP_PINS = 4,
    parameter int N_PER    = 4,
    localparam int N_SRC   = N_EXT + N_PER,
    localparam int VEC_W   = vec_width(N_SRC)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_EXT*GRP_PINS-1:0] pin_in,
    input  logic [N_EXT*GRP_PINS-1:0] pin_sel,
    input  logic [N_PER-1:0]          per_req,
    input  logic [N_SRC-1:0]          src_en,
    input  logic [2*N_SRC-1:0]        src_lvl,
    input  logic [N_SRC-1:0]          src_clr,
    input  logic                      nmi_reset,
    input  logic                      nmi_pin,
    input  logic                      nmi_trap,
    input  logic                      core_ack,
    input  logic                      core_ready,
    input  logic                      ret_stb,
    input  logic [1:0]                ret_lvl,
    output logic [1:0]                cur_lvl,
    output logic                      win_valid,
    output logic [VEC_W-1:0]          win_vec,
    output logic                      ent_stb,
    output logic [VEC_W-1:0]          ent_vec,
    output logic                      ent_stack,
    output logic                      wake
);
    logic [N_EXT-1:0] ext_rise;
    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] ent_clr;
    nmi_set_t         nmi_pend;
    nmi_set_t         nmi_take;
    logic             nmi_pin_q;
    logic             armed;
    logic             accept;
    logic             win_nmi;
    lvl_t             win_lvl;
    lvl_t             lvl_q;
    entry_t           ent_q;
    logic [VEC_W-1:0] ent_vec_q;

    irq_ext_group #(.N_EXT(N_EXT), .GRP_PINS(GRP_PINS)) u_grp (
        .clk(clk), .rst(rst), .pin_in(pin_in), .pin_sel(pin_sel), .rise(ext_rise)
    );

    irq_pend_bank #(.N_EXT(N_EXT), .N_PER(N_PER)) u_pend (
        .clk(clk), .rst(rst), .ext_rise(ext_rise), .per_req(per_req),
        .clr(src_clr), .ent_clr(ent_clr), .pend(pend)
    );

    irq_two_stage_pick #(.N_SRC(N_SRC)) u_pick (
        .clk(clk), .rst(rst), .pend(pend), .en(src_en), .lvl(src_lvl),
        .cur(lvl_q), .nmi_pend(nmi_pend), .win_valid(win_valid),
        .win_nmi(win_nmi), .win_lvl(win_lvl), .win_code(win_vec)
    );

    assign accept = core_ack & armed & win_valid;

    for (genvar i = 0; i < N_SRC; i++) begin : g_entclr
        assign ent_clr[i] = accept & ~win_nmi & (win_vec == VEC_W'(i + NMI_CNT));
    end

    always_comb begin
        nmi_take      = '0;
        nmi_take.rst  = accept & win_nmi & (win_vec == VEC_W'(NMI_RST));
        nmi_take.pin  = accept & win_nmi & (win_vec == VEC_W'(NMI_PIN));
        nmi_take.trap = accept & win_nmi & (win_vec == VEC_W'(NMI_TRAP));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_pend  <= '0;
            nmi_pin_q <= 1'b0;
            lvl_q     <= LVL_TOP;
            armed     <= 1'b1;
            ent_q     <= '0;
            ent_vec_q <= '0;
        end else begin
            nmi_pin_q     <= nmi_pin;
            nmi_pend.rst  <= (nmi_pend.rst  | nmi_reset) & ~nmi_take.rst;
            nmi_pend.pin  <= (nmi_pend.pin  | (nmi_pin & ~nmi_pin_q)) & ~nmi_take.pin;
            nmi_pend.trap <= (nmi_pend.trap | nmi_trap) & ~nmi_take.trap;
            ent_q.stb     <= accept;
            if (accept) begin
                lvl_q       <= win_nmi ? LVL_TOP : win_lvl;
                armed       <= 1'b0;
                ent_vec_q   <= win_vec;
                ent_q.stack <= ~(win_nmi & (win_vec == VEC_W'(NMI_RST)));
            end else begin
                if (ret_stb)    lvl_q <= ret_lvl;
                if (core_ready) armed <= 1'b1;
            end
        end
    end

    assign cur_lvl   = lvl_q;
    assign ent_stb   = ent_q.stb;
    assign ent_stack = ent_q.stack;
    assign ent_vec   = ent_vec_q;
    assign wake      = (|(pend[N_EXT-1:0] & src_en[N_EXT-1:0])) | nmi_any(nmi_pend);

    p_nmi_level_top_r5: assert property (@(posedge clk) disable iff (rst)
        (accept && win_nmi) |=> (cur_lvl == LVL_TOP));
    p_mask_level_load_r5: assert property (@(posedge clk) disable iff (rst)
        (accept && !win_nmi) |=> (cur_lvl == $past(win_lvl)));
    p_unarmed_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (core_ack && !armed) |=> !ent_stb);
    p_reset_no_stack_r6: assert property (@(posedge clk) disable iff (rst)
        (ent_stb && ent_vec == VEC_W'(NMI_RST)) |-> !ent_stack);
    p_restore_r11: assert property (@(posedge clk) disable iff (rst)
        (ret_stb && !accept) |=> (cur_lvl == $past(ret_lvl)));
endmodule

// File: tb/nest_irq_arbiter_bench.sv
module nest_irq_arbiter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_EXT = 2, GRP_PINS = 4, N_PER = 4;
    localparam int N_SRC = N_EXT + N_PER;
    localparam int VEC_W = 4;
    // vector: {req[4], en[4], lvl[8] (p3..p0), cur[2], exp_valid, exp_vec[4]}
    localparam int TW = 23;
    localparam int NV = 9;
    localparam logic [TW-1:0] TBL [NV] = '{
        {4'b0011, 4'b1111, 8'b00_00_10_01, 2'd0, 1'b1, 4'd6}, // R1 level decides
        {4'b1111, 4'b1111, 8'b10_10_10_10, 2'd0, 1'b1, 4'd5}, // R2 tie -> lowest
        {4'b1100, 4'b1111, 8'b01_01_00_00, 2'd0, 1'b1, 4'd7}, // R2
        {4'b1111, 4'b1111, 8'b11_01_11_10, 2'd0, 1'b1, 4'd6}, // R1 then R2
        {4'b0001, 4'b1111, 8'b00_00_00_01, 2'd1, 1'b0, 4'd0}, // R3 equal level
        {4'b0001, 4'b1111, 8'b00_00_00_10, 2'd1, 1'b1, 4'd5}, // R3 above level
        {4'b0110, 4'b1011, 8'b00_11_01_00, 2'd0, 1'b1, 4'd6}, // R3 disabled
        {4'b1000, 4'b1111, 8'b11_00_00_00, 2'd3, 1'b0, 4'd0}, // R3 level 3
        {4'b0000, 4'b1111, 8'b00_00_00_00, 2'd0, 1'b0, 4'd0}  // nothing
    };

    logic clk = 0, rst = 1;
    logic [N_EXT*GRP_PINS-1:0] pin_in = '0, pin_sel = '0;
    logic [N_PER-1:0] per_req = '0;
    logic [N_SRC-1:0] src_en = '0, src_clr = '0;
    logic [2*N_SRC-1:0] src_lvl = '0;
    logic nmi_reset = 0, nmi_pin = 0, nmi_trap = 0;
    logic core_ack = 0, core_ready = 0, ret_stb = 0;
    logic [1:0] ret_lvl = '0;
    logic [1:0] cur_lvl;
    logic win_valid, ent_stb, ent_stack, wake;
    logic [VEC_W-1:0] win_vec, ent_vec;
    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nest_irq_arbiter #(.N_EXT(N_EXT), .GRP_PINS(GRP_PINS), .N_PER(N_PER)) u_nest_irq_arbiter (
        .clk(clk), .rst(rst), .pin_in(pin_in), .pin_sel(pin_sel), .per_req(per_req),
        .src_en(src_en), .src_lvl(src_lvl), .src_clr(src_clr), .nmi_reset(nmi_reset),
        .nmi_pin(nmi_pin), .nmi_trap(nmi_trap), .core_ack(core_ack),
        .core_ready(core_ready), .ret_stb(ret_stb), .ret_lvl(ret_lvl),
        .cur_lvl(cur_lvl), .win_valid(win_valid), .win_vec(win_vec),
        .ent_stb(ent_stb), .ent_vec(ent_vec), .ent_stack(ent_stack), .wake(wake)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear_all();
        step(); src_clr = '1;
        step(); src_clr = '0;
    endtask

    task automatic restore(input logic [1:0] l);
        step(); ret_stb = 1; ret_lvl = l;
        step(); ret_stb = 0;
    endtask

    task automatic ack();
        step(); core_ack = 1;
        step(); core_ack = 0;
    endtask

    task automatic ready();
        step(); core_ready = 1;
        step(); core_ready = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) step();
        rst = 0;
        step();
        // R13 reset state
        check("R13 cur_lvl", cur_lvl, 3);
        check("R13 win_valid", win_valid, 0);
        check("R13 ent_stb", ent_stb, 0);
        check("R13 wake", wake, 0);

        for (int v = 0; v < NV; v++) begin
            clear_all();
            step();
            src_en  = {TBL[v][18:15], 2'b00};
            src_lvl = {TBL[v][14:7], 4'b0000};
            ret_stb = 1; ret_lvl = TBL[v][6:5];
            per_req = TBL[v][22:19];
            step();
            ret_stb = 0; per_req = '0;
            check("R1/R2/R3 table valid", win_valid, int'(TBL[v][4]));
            if (TBL[v][4]) check("R1/R2/R3 table vec", win_vec, int'(TBL[v][3:0]));
        end

        // R4 non-maskable precedence over a level-3 maskable source
        clear_all();
        src_en = '1; src_lvl = {8'b00_00_00_11, 4'b0000};
        restore(2'd0);
        step(); per_req = 4'b0001; nmi_trap = 1; nmi_pin = 1;
        step(); per_req = '0; nmi_trap = 0; nmi_pin = 0;
        check("R4 pin over trap and maskable", win_vec, 1);
        check("R12 wake on nmi", wake, 1);
        ack();
        check("R5 nmi entry strobe", ent_stb, 1);
        check("R5 nmi entry vec", ent_vec, 1);
        check("R6 pin entry stacks", ent_stack, 1);
        check("R5 nmi sets level 3", cur_lvl, 3);
        check("R4 trap next", win_vec, 2);
        // R10 acknowledge ignored while disarmed
        ack();
        check("R10 no entry unarmed", ent_stb, 0);
        check("R10 trap still waiting", win_vec, 2);
        ready();
        ack();
        check("R10 entry after ready", ent_stb, 1);
        check("R10 trap entered", ent_vec, 2);
        check("R3 level 3 masks maskable", win_valid, 0);
        step(); nmi_reset = 1;
        step(); nmi_reset = 0;
        check("R4 reset code", win_vec, 0);
        ready();
        ack();
        check("R6 reset vec", ent_vec, 0);
        check("R6 reset no stack", ent_stack, 0);

        // R11 restore, R5 maskable load, R9 peripheral latch persists
        restore(2'd1);
        check("R11 restore level", cur_lvl, 1);
        check("R3 level3 above 1", win_vec, 5);
        ready();
        ack();
        check("R5 maskable entry vec", ent_vec, 5);
        check("R5 maskable level load", cur_lvl, 3);
        restore(2'd0);
        check("R9 peripheral kept after entry", win_valid, 1);
        check("R9 peripheral kept vec", win_vec, 5);
        step(); src_clr = 6'b000100;
        step(); src_clr = '0;
        check("R9 clear discards", win_valid, 0);

        // R7/R8 external group 0
        clear_all();
        src_en = 6'b000001; src_lvl = 12'b0000_0000_0001;
        pin_sel = 8'b0000_0101;
        step(); pin_in = 8'b0000_0010;
        step();
        step();
        check("R8 unselected pin ignored", win_valid, 0);
        check("R8 unselected no wake", wake, 0);
        pin_in = 8'b0000_0110;
        step();
        check("R8 selected pin latched", win_vec, 3);
        check("R12 wake on external", wake, 1);
        ready();
        ack();
        check("R7 external entered", ent_vec, 3);
        restore(2'd0);
        check("R7 entry clears latch", win_valid, 0);
        step(); pin_in = 8'b0000_0111;
        step();
        check("R7 held line no relatch", win_valid, 0);
        pin_in = '0;
        step(); pin_in = 8'b0000_0001;
        step();
        check("R7 new edge relatched", win_vec, 3);
        src_en = '0;
        step();
        check("R12 disabled external no wake", wake, 0);
        step(); src_clr = 6'b000001;
        step(); src_clr = '0; src_en = 6'b000001;
        step();
        check("R9 external clear discards", win_valid, 0);
        check("R9 external clear wake", wake, 0);

        finish_run();
    end
endmodule